// File: doc/BRIEF.md
# Operand Read-Request Gating Unit

This unit sits between a decoded-instruction record and the register-file read ports of one function unit. That function unit has four operand slots. Slot 0 is integer operand A. Slot 1 is integer operand B. Slot 2 is the summary-overflow flag of the fixed-point exception register (bit 32). Slot 3 is the carry pair of that register (bits 34 and 45).

For every instruction it issues, the unit decides which of those slots the instruction really needs. It raises a read request only on the ports that are needed, and it suppresses the rest. For the two integer operands it also supplies the register selector as a one-hot mask, not as a binary index.

The request set is captured on an issue strobe. It is then held steady until the function unit acknowledges it. While a set is held, a new issue is accepted only in the same cycle as the acknowledge.

Top module: `rdgate_unit`

## Requirements
- R1: A synchronous active-high reset clears `vld_o`, all four request bits and both select masks to zero.
- R2: Request bit 0 (operand A) is 1 exactly when the captured instruction marked operand A as valid.
- R3: Each integer select mask equals 1 shifted left by the captured register number when its request bit is 1, and is all-zero when its request bit is 0.
- R4: Request bit 1 (operand B) is 1 only when operand B was marked valid and the immediate-select flag was 0.
- R5: Request bit 2 (overflow flag) equals the captured OE bit.
- R6: Request bit 3 (carry pair) equals the captured carry-in-select flag.
- R7: The Rc bit has no effect on any request bit or select mask.
- R8: An accepted issue drives `vld_o` and the new request set on the clock edge that captures it, so they are visible one cycle after the issue.
- R9: While `vld_o` is 1 and `ack_i` is 0, the outputs stay unchanged, and an issue strobe is ignored.
- R10: `ack_i` with no issue clears `vld_o`, the requests and the masks. `ack_i` together with `issue_i` loads the new instruction's request set instead, and `vld_o` stays at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_i | input | 1 | Strobe: a decoded instruction is presented |
| ack_i | input | 1 | Function unit has taken the held request set |
| ra_vld_i | input | 1 | Decoder marks operand A as read |
| ra_num_i | input | 5 | Operand A register number |
| rb_vld_i | input | 1 | Decoder marks operand B as read |
| rb_num_i | input | 5 | Operand B register number |
| imm_sel_i | input | 1 | Immediate replaces operand B |
| oe_i | input | 1 | Overflow-enable bit of the instruction |
| rc_i | input | 1 | Record bit of the instruction |
| cin_sel_i | input | 1 | Operation consumes the carry input |
| vld_o | output | 1 | A request set is held for the function unit |
| req_o | output | 4 | Per-slot read requests: bit0 A, bit1 B, bit2 overflow, bit3 carry |
| ra_sel_o | output | 32 | One-hot select for operand A |
| rb_sel_o | output | 32 | One-hot select for operand B |

## Verification
Two events can land on the same clock edge: the acknowledge that retires the held request set, and the issue of the next instruction. The bench provokes this by raising `ack_i` and `issue_i` together, with fields that differ from the held set. It then expects the new set to appear with `vld_o` still at 1, and not a cleared cycle. It also applies an issue without an acknowledge, and expects that issue to be dropped while the old set stays in place.

// File: rtl/rdgate_pkg.sv
package rdgate_pkg;

    localparam int unsigned NREG  = 32;
    localparam int unsigned IDX_W = $clog2(NREG);
    localparam int unsigned NSLOT = 4;

    // slot order is fixed: the read-port wiring of the function unit decodes it
    typedef enum logic [1:0] {
        SLOT_RA = 2'd0,
        SLOT_RB = 2'd1,
        SLOT_SO = 2'd2,
        SLOT_CA = 2'd3
    } slot_e;

    // exception-register bit positions served by slots 2 and 3
    localparam int unsigned XER_SO_BIT   = 32;
    localparam int unsigned XER_CA_BIT   = 34;
    localparam int unsigned XER_CA32_BIT = 45;

    typedef struct packed {
        logic [NSLOT-1:0] req;
        logic [NREG-1:0]  ra_sel;
        logic [NREG-1:0]  rb_sel;
    } port_req_t;

endpackage

// File: rtl/rdgate_onehot.sv
module rdgate_onehot #(
    parameter int unsigned N = 32,
    parameter int unsigned W = $clog2(N)
) (
    input  logic         en_i,
    input  logic [W-1:0] idx_i,
    output logic [N-1:0] sel_o
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        assign sel_o[i] = en_i && (idx_i == W'(i));
    end

    always_comb begin
        a_r3_onehot_legal: assert ($onehot0(sel_o));
    end
endmodule

// File: rtl/rdgate_flags.sv
module rdgate_flags
    import rdgate_pkg::*;
(
    input  logic             ra_vld_i,
    input  logic             rb_vld_i,
    input  logic             imm_sel_i,
    input  logic             oe_i,
    input  logic             cin_sel_i,
    output logic [NSLOT-1:0] want_o
);
    always_comb begin
        want_o          = '0;
        want_o[SLOT_RA] = ra_vld_i;
        want_o[SLOT_RB] = rb_vld_i && !imm_sel_i;
        want_o[SLOT_SO] = oe_i;
        want_o[SLOT_CA] = cin_sel_i;
    end
endmodule

// File: rtl/rdgate_hold.sv
module rdgate_hold
    import rdgate_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      issue_i,
    input  logic      ack_i,
    input  port_req_t nxt_i,
    output logic      vld_o,
    output port_req_t cur_o
);
    logic take;
    assign take = issue_i && (!vld_o || ack_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_o <= 1'b0;
            cur_o <= '0;
        end else if (take) begin
            vld_o <= 1'b1;
            cur_o <= nxt_i;
        end else if (ack_i) begin
            vld_o <= 1'b0;
            cur_o <= '0;
        end
    end

    a_r9_held_stable: assert property (@(posedge clk) disable iff (rst)
        (vld_o && !ack_i) |=> (vld_o && $stable(cur_o)));
    a_r8_issue_valid: assert property (@(posedge clk) disable iff (rst)
        (issue_i && (!vld_o || ack_i)) |=> vld_o);
    a_r10_ack_clears: assert property (@(posedge clk) disable iff (rst)
        (vld_o && ack_i && !issue_i) |=> (!vld_o && cur_o == '0));
endmodule

// File: rtl/rdgate_unit.sv
module rdgate_unit
    import rdgate_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             issue_i,
    input  logic             ack_i,
    input  logic             ra_vld_i,
    input  logic [IDX_W-1:0] ra_num_i,
    input  logic             rb_vld_i,
    input  logic [IDX_W-1:0] rb_num_i,
    input  logic             imm_sel_i,
    input  logic             oe_i,
    input  logic             rc_i,
    input  logic             cin_sel_i,
    output logic             vld_o,
    output logic [NSLOT-1:0] req_o,
    output logic [NREG-1:0]  ra_sel_o,
    output logic [NREG-1:0]  rb_sel_o
);
    logic [NSLOT-1:0] want;
    port_req_t        nxt;
    port_req_t        cur;

    rdgate_flags u_flags (
        .ra_vld_i  (ra_vld_i),
        .rb_vld_i  (rb_vld_i),
        .imm_sel_i (imm_sel_i),
        .oe_i      (oe_i),
        .cin_sel_i (cin_sel_i),
        .want_o    (want)
    );

    rdgate_onehot #(.N(NREG), .W(IDX_W)) u_ra_dec (
        .en_i  (want[SLOT_RA]),
        .idx_i (ra_num_i),
        .sel_o (nxt.ra_sel)
    );

    rdgate_onehot #(.N(NREG), .W(IDX_W)) u_rb_dec (
        .en_i  (want[SLOT_RB]),
        .idx_i (rb_num_i),
        .sel_o (nxt.rb_sel)
    );

    assign nxt.req = want;

    rdgate_hold u_hold (
        .clk     (clk),
        .rst     (rst),
        .issue_i (issue_i),
        .ack_i   (ack_i),
        .nxt_i   (nxt),
        .vld_o   (vld_o),
        .cur_o   (cur)
    );

    assign req_o    = cur.req;
    assign ra_sel_o = cur.ra_sel;
    assign rb_sel_o = cur.rb_sel;

    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (!vld_o && req_o == '0 && ra_sel_o == '0 && rb_sel_o == '0));
    a_r3_ra_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !req_o[SLOT_RA] |-> (ra_sel_o == '0));
    a_r3_rb_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !req_o[SLOT_RB] |-> (rb_sel_o == '0));
    a_r4_imm_blocks_rb: assert property (@(posedge clk) disable iff (rst)
        (issue_i && (!vld_o || ack_i) && imm_sel_i) |=> !req_o[SLOT_RB]);
    a_r5_so_needs_oe: assert property (@(posedge clk) disable iff (rst)
        (issue_i && (!vld_o || ack_i) && !oe_i) |=> !req_o[SLOT_SO]);
    a_r7_rc_no_carry: assert property (@(posedge clk) disable iff (rst)
        (issue_i && (!vld_o || ack_i) && rc_i && !cin_sel_i) |=> !req_o[SLOT_CA]);
    a_r2_idle_no_req: assert property (@(posedge clk) disable iff (rst)
        !vld_o |-> (req_o == '0));
endmodule

// File: tb/tb_rdgate_unit.sv
`timescale 1ns/1ps
module tb_rdgate_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        issue_i, ack_i, ra_vld_i, rb_vld_i, imm_sel_i, oe_i, rc_i, cin_sel_i;
    logic [4:0]  ra_num_i, rb_num_i;
    logic        vld_o;
    logic [3:0]  req_o;
    logic [31:0] ra_sel_o, rb_sel_o;

    always #2 clk = ~clk;

    rdgate_unit dut (
        .clk(clk), .rst(rst), .issue_i(issue_i), .ack_i(ack_i),
        .ra_vld_i(ra_vld_i), .ra_num_i(ra_num_i), .rb_vld_i(rb_vld_i),
        .rb_num_i(rb_num_i), .imm_sel_i(imm_sel_i), .oe_i(oe_i), .rc_i(rc_i),
        .cin_sel_i(cin_sel_i), .vld_o(vld_o), .req_o(req_o),
        .ra_sel_o(ra_sel_o), .rb_sel_o(rb_sel_o)
    );

    typedef struct {
        logic        vld;
        logic [3:0]  req;
        logic [31:0] ras;
        logic [31:0] rbs;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    int          checks = 0;
    int          errors = 0;
    bit          done = 0;
    // bench-side model state
    logic        m_vld = 0;
    logic [3:0]  m_req = 0;
    logic [31:0] m_ras = 0, m_rbs = 0;

    task automatic step(input logic iss, input logic ack, input logic rav, input logic [4:0] ran,
                        input logic rbv, input logic [4:0] rbn, input logic imm, input logic oe,
                        input logic rc, input logic cin, input string tag);
        exp_t e;
        @(negedge clk);
        issue_i = iss; ack_i = ack; ra_vld_i = rav; ra_num_i = ran; rb_vld_i = rbv;
        rb_num_i = rbn; imm_sel_i = imm; oe_i = oe; rc_i = rc; cin_sel_i = cin;
        if (iss && (!m_vld || ack)) begin
            m_vld = 1;
            m_req = {cin, oe, rbv && !imm, rav};
            m_ras = rav ? (32'd1 << ran) : 32'd0;
            m_rbs = (rbv && !imm) ? (32'd1 << rbn) : 32'd0;
        end else if (ack) begin
            m_vld = 0; m_req = 0; m_ras = 0; m_rbs = 0;
        end
        e.vld = m_vld; e.req = m_req; e.ras = m_ras; e.rbs = m_rbs; e.tag = tag;
        sb.push_back(e);
    endtask

    // monitor: compares one cycle after each captured edge
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (vld_o !== e.vld || req_o !== e.req || ra_sel_o !== e.ras || rb_sel_o !== e.rbs) begin
                errors++;
                $display("FAIL %s: got vld=%b req=%b ra=%h rb=%h exp vld=%b req=%b ra=%h rb=%h",
                         e.tag, vld_o, req_o, ra_sel_o, rb_sel_o, e.vld, e.req, e.ras, e.rbs);
            end
        end
    end

    initial begin
        #400000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got hang exp completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1; issue_i = 0; ack_i = 0; ra_vld_i = 0; ra_num_i = 0; rb_vld_i = 0;
        rb_num_i = 0; imm_sel_i = 0; oe_i = 0; rc_i = 0; cin_sel_i = 0;
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (vld_o !== 0 || req_o !== 0 || ra_sel_o !== 0 || rb_sel_o !== 0) begin
            errors++;
            $display("FAIL R1: got vld=%b req=%b ra=%h rb=%h exp all zero",
                     vld_o, req_o, ra_sel_o, rb_sel_o);
        end
        @(negedge clk); rst = 0;

        // R2 R3 R5 R6: all slots wanted
        step(1, 0, 1, 5'd5, 1, 5'd31, 0, 1, 0, 1, "R2/R5/R6 full set");
        // R9: held, a new issue without ack is dropped
        step(1, 0, 0, 5'd9, 0, 5'd9, 1, 0, 1, 0, "R9 issue ignored while held");
        step(0, 0, 0, 5'd0, 0, 5'd0, 0, 0, 0, 0, "R9 hold");
        // R10 + R4: ack and issue together, immediate blocks operand B
        step(1, 1, 0, 5'd3, 1, 5'd7, 1, 0, 1, 0, "R10 ack with issue / R4 imm");
        // R10: ack alone clears
        step(0, 1, 0, 5'd0, 0, 5'd0, 0, 0, 0, 0, "R10 ack clears");
        // R3: one-hot at several indices
        for (int k = 0; k < 5; k++) begin
            automatic logic [4:0] n = (k == 0) ? 5'd0 : (k == 1) ? 5'd1 :
                                      (k == 2) ? 5'd15 : (k == 3) ? 5'd30 : 5'd31;
            step(1, 1, 1, n, 1, 5'd31 - n, 0, 0, 0, 0, "R3 one-hot index");
        end
        step(0, 1, 0, 5'd0, 0, 5'd0, 0, 0, 0, 0, "R10 ack clears");
        // R7: rc toggled alone makes no difference
        step(1, 0, 1, 5'd12, 0, 5'd4, 0, 0, 0, 1, "R7 rc=0");
        step(1, 1, 1, 5'd12, 0, 5'd4, 0, 0, 1, 1, "R7 rc=1");
        step(1, 1, 0, 5'd2, 0, 5'd2, 0, 0, 1, 0, "R7 rc only");
        // R8: issue from idle gives valid after one edge
        step(0, 1, 0, 5'd0, 0, 5'd0, 0, 0, 0, 0, "R10 ack clears");
        step(1, 0, 0, 5'd0, 1, 5'd17, 0, 1, 0, 0, "R8 latency / R5 oe");
        step(0, 1, 0, 5'd0, 0, 5'd0, 0, 0, 0, 0, "R10 ack clears");
        @(negedge clk); issue_i = 0; ack_i = 0;
        repeat (3) @(posedge clk);
        #2;
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule